// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block holds the transmit and receive error counters of a CAN node and works out from them the error state the node is in. The protocol engine beside it detects errors and completed transfers. It reports each one as a single-cycle event pulse. It also presents every sampled bus bit, as a tick together with the bit's level. From these inputs the unit updates both counters and moves between five states: synchronizing, error active, error warning, error passive and bus off.

Two outputs tell the engine how to behave. `drv_en` allows the transmit driver only while the node takes part in bus traffic. `flag_dom` tells the engine whether an error flag it raises may be dominant. The unit also counts dominant bits that follow an error or overload flag, which it needs for the heavy-disturbance penalties. It counts runs of recessive bits for start-up and for bus-off recovery.

Top module: `can_fault_conf`

## Requirements
- R1: After reset the state output `st_o` reads 0 (synchronizing; the other codes are 1 active, 2 warning, 3 passive, 4 bus off), both counters read 0 and `drv_en` is low. Error events in this state change nothing. The state becomes active on the 11th consecutive recessive bit tick, and a dominant tick restarts that count.
- R2: The state is warning (2) when either counter is at least 96 and neither exceeds 127. It returns to active (1) once both counters are below 96.
- R3: The state is passive (3) when either counter exceeds 127 and the transmit counter does not exceed 255. In this state `flag_dom` is low. `flag_dom` is high in active and warning. The state leaves passive once both counters are below 128.
- R4: When the transmit counter exceeds 255 the state is bus off (4), `drv_en` is low and `tec_o` reads 255. Counter events are then ignored.
- R5: In bus off, on the 128th run of 11 consecutive recessive ticks, the state becomes active with both counters 0. A dominant tick restarts only the current run.
- R6: `ev_rx_err` adds 1 to the receive counter. `ev_tx_err` adds 8 to the transmit counter.
- R7: `ev_flag_bit_err` adds 8 to the transmit counter when `tx_role` is 1, and to the receive counter otherwise.
- R8: While `flag_window` is high, the counter chosen by `tx_role` gets +8 on a given dominant tick. With `flag_passive` low, that is the 14th consecutive dominant tick. With `flag_passive` high, it is the 8th. After that the counter gets +8 on every further 8th dominant tick. A recessive tick or a low `flag_window` restarts the count.
- R9: `ev_rx_ok` and `ev_tx_ok` subtract 1 from the receive and transmit counter respectively, but never go below 0.
- R10: Once bit 7 of the receive counter is set, no event increments it.
- R11: `ev_tx_err` with `ex_arb_stuff` high never changes the transmit counter. `ev_tx_err` with `ex_ack_quiet` high leaves the counter unchanged in passive, and adds 8 in any other state.
- R12: Driving `enable` low clears both counters and returns the state to synchronizing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Node enable; low holds the unit cleared in synchronizing |
| bit_tick | input | 1 | One pulse per sampled bus bit |
| bit_rec | input | 1 | Level of the ticked bit, 1 = recessive |
| flag_window | input | 1 | High during the bits that follow an error or overload flag |
| flag_passive | input | 1 | The flag before the window was a passive error flag |
| tx_role | input | 1 | The node was transmitter (selects the counter for +8 penalties) |
| ev_rx_err | input | 1 | Ordinary error seen as receiver |
| ev_tx_err | input | 1 | Ordinary error seen as transmitter |
| ex_arb_stuff | input | 1 | Qualifies ev_tx_err: stuff error in arbitration (exempt) |
| ex_ack_quiet | input | 1 | Qualifies ev_tx_err: ACK error with a quiet passive flag |
| ev_flag_bit_err | input | 1 | Bit error while sending an active error flag |
| ev_rx_ok | input | 1 | Successful reception |
| ev_tx_ok | input | 1 | Successful transmission |
| tec_o | output | 8 | Transmit error counter, reads 255 when above 255 |
| rec_o | output | 8 | Receive error counter |
| st_o | output | 3 | Error state code |
| drv_en | output | 1 | Transmit driver enable |
| flag_dom | output | 1 | Error flags may be sent dominant |

## Verification
Seeded random bursts mix receive and transmit errors, both exemptions, flag bit errors and successes with a random role. The share of successes is set so that the counters rise through warning and passive and sometimes reach bus off. These bursts separate the +1 and +8 steps, the floor at zero and the receive-counter freeze, which a per-event model predicts. Directed sequences then check each boundary: 95/96, 127/128 and 255/256. They also cover a dominant tick inside the start-up run and inside the last bus-off recovery run, the 13th versus 14th and 7th versus 8th dominant tick after a flag, and the ACK exemption in active versus passive.

// File: rtl/can_fc_pkg.sv
// Shared types for the fault confinement unit.
// Assumes: state codes are visible at the top's ports and must not be reordered.
package can_fc_pkg;
    localparam int CNT_W = 8;
    localparam int TEC_W = CNT_W + 1;

    typedef enum logic [2:0] {
        FC_SYNC    = 3'd0,
        FC_ACTIVE  = 3'd1,
        FC_WARN    = 3'd2,
        FC_PASSIVE = 3'd3,
        FC_BUSOFF  = 3'd4
    } fc_state_e;

    typedef enum logic [1:0] {
        MD_SYNC = 2'd0,
        MD_RUN  = 2'd1,
        MD_BOFF = 2'd2
    } fc_mode_e;
endpackage

// File: rtl/can_fc_runs.sv
// Recessive run detector: pulses done on the tick that completes RUN_LEN
// consecutive recessive bits, then starts a new run.
// Assumes: bit_tick is at most one cycle per bus bit.
module can_fc_runs #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_tick,
    input  logic bit_rec,
    output logic done
);
    localparam int W = $clog2(RUN_LEN + 1);

    logic [W-1:0] cnt;

    // completion of a run on this tick
    assign done = !clr && bit_tick && bit_rec && (cnt == W'(RUN_LEN - 1));

    // run length register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (bit_tick) begin
            if (!bit_rec || done)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/can_fc_dom_mon.sv
// Post-flag dominant bit monitor: raises inc8 on the ACT_THR-th (or PAS_THR-th
// after a passive flag) consecutive dominant bit and on every STEP-th after.
// Assumes: flag_window is high only in the bits following a flag.
module can_fc_dom_mon #(
    parameter int ACT_THR = 14,
    parameter int PAS_THR = 8,
    parameter int STEP    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bit_rec,
    input  logic flag_window,
    input  logic flag_passive,
    output logic inc8
);
    localparam int W = $clog2(ACT_THR + 1);

    logic [W-1:0] run;
    logic [W-1:0] thr;
    logic [W-1:0] nxt;
    logic         dom;

    // threshold pick and penalty decode
    always_comb begin
        dom  = bit_tick && !bit_rec && flag_window;
        thr  = flag_passive ? W'(PAS_THR) : W'(ACT_THR);
        nxt  = run + 1'b1;
        inc8 = dom && (nxt >= thr);
    end

    // consecutive dominant count
    always_ff @(posedge clk) begin
        if (!rst_n || !flag_window)
            run <= '0;
        else if (bit_tick) begin
            if (bit_rec)
                run <= '0;
            else if (inc8)
                run <= thr - W'(STEP);
            else
                run <= nxt;
        end
    end
endmodule

// File: rtl/can_fc_counters.sv
// Transmit and receive error counters with the exemption and freeze rules.
// Assumes: increments win over a success in the same cycle; hold freezes both.
module can_fc_counters
    import can_fc_pkg::*;
#(
    parameter int ERR_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic             is_passive,
    input  logic             tx_role,
    input  logic             ev_rx_err,
    input  logic             ev_tx_err,
    input  logic             ex_arb_stuff,
    input  logic             ex_ack_quiet,
    input  logic             ev_flag_bit_err,
    input  logic             dom_inc8,
    input  logic             ev_rx_ok,
    input  logic             ev_tx_ok,
    output logic [TEC_W-1:0] tec,
    output logic [CNT_W-1:0] rec
);
    logic tx_up;
    logic rx_big;
    logic rx_req;

    // which counters are asked to rise this cycle
    always_comb begin
        tx_up  = (ev_tx_err && !ex_arb_stuff && !(ex_ack_quiet && is_passive))
               || (tx_role && (ev_flag_bit_err || dom_inc8));
        rx_big = !tx_role && (ev_flag_bit_err || dom_inc8);
        rx_req = rx_big || ev_rx_err;
    end

    // transmit counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            tec <= '0;
        else if (!hold) begin
            if (tx_up)
                tec <= tec + TEC_W'(ERR_STEP);
            else if (ev_tx_ok && tec != '0)
                tec <= tec - 1'b1;
        end
    end

    // receive counter, frozen upward once bit 7 is set
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            rec <= '0;
        else if (!hold) begin
            if (rx_req) begin
                if (!rec[CNT_W-1])
                    rec <= rec + (rx_big ? CNT_W'(ERR_STEP) : CNT_W'(1));
            end else if (ev_rx_ok && rec != '0)
                rec <= rec - 1'b1;
        end
    end
endmodule

// File: rtl/can_fault_conf.sv
// Fault confinement top: runs the start-up and bus-off recovery sequencing,
// derives the error state from the counters and drives the output controls.
// Assumes: all ev_* inputs are single-cycle pulses from the protocol engine.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int BOFF_RUNS = 128,
    parameter int WARN_LVL  = 96,
    parameter int PASS_LVL  = 128,
    parameter int BOFF_LVL  = 256,
    parameter int ERR_STEP  = 8,
    parameter int ACT_DOM   = 14,
    parameter int PAS_DOM   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       bit_tick,
    input  logic       bit_rec,
    input  logic       flag_window,
    input  logic       flag_passive,
    input  logic       tx_role,
    input  logic       ev_rx_err,
    input  logic       ev_tx_err,
    input  logic       ex_arb_stuff,
    input  logic       ex_ack_quiet,
    input  logic       ev_flag_bit_err,
    input  logic       ev_rx_ok,
    input  logic       ev_tx_ok,
    output logic [7:0] tec_o,
    output logic [7:0] rec_o,
    output logic [2:0] st_o,
    output logic       drv_en,
    output logic       flag_dom
);
    localparam int OCC_W = $clog2(BOFF_RUNS);

    fc_mode_e         mode;
    fc_state_e        st;
    logic [OCC_W-1:0] occ;
    logic [TEC_W-1:0] tec;
    logic [CNT_W-1:0] rec;
    logic             run_done;
    logic             run_clr;
    logic             dom_inc8;
    logic             boff_hit;
    logic             passive;
    logic             warn;
    logic             recover;
    logic             cnt_clr;
    logic             hold;

    // level decode and sequencing controls
    always_comb begin
        boff_hit = tec >= TEC_W'(BOFF_LVL);
        passive  = (tec >= TEC_W'(PASS_LVL)) || (rec >= CNT_W'(PASS_LVL));
        warn     = (tec >= TEC_W'(WARN_LVL)) || (rec >= CNT_W'(WARN_LVL));
        run_clr  = !enable || mode == MD_RUN;
        recover  = mode == MD_BOFF && run_done && occ == OCC_W'(BOFF_RUNS - 1);
        cnt_clr  = !enable || recover;
        hold     = mode != MD_RUN || boff_hit;
    end

    can_fc_runs #(.RUN_LEN(RUN_LEN)) i_runs (
        .clk(clk), .rst_n(rst_n), .clr(run_clr),
        .bit_tick(bit_tick), .bit_rec(bit_rec), .done(run_done)
    );

    can_fc_dom_mon #(.ACT_THR(ACT_DOM), .PAS_THR(PAS_DOM), .STEP(ERR_STEP)) i_dom (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_rec(bit_rec),
        .flag_window(flag_window), .flag_passive(flag_passive), .inc8(dom_inc8)
    );

    can_fc_counters #(.ERR_STEP(ERR_STEP)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .hold(hold),
        .is_passive(passive), .tx_role(tx_role),
        .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err),
        .ex_arb_stuff(ex_arb_stuff), .ex_ack_quiet(ex_ack_quiet),
        .ev_flag_bit_err(ev_flag_bit_err), .dom_inc8(dom_inc8),
        .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .tec(tec), .rec(rec)
    );

    // participation mode and recovery run count
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            mode <= MD_SYNC;
            occ  <= '0;
        end else begin
            case (mode)
                MD_SYNC: if (run_done) mode <= MD_RUN;
                MD_RUN: begin
                    if (boff_hit) begin
                        mode <= MD_BOFF;
                        occ  <= '0;
                    end
                end
                MD_BOFF: begin
                    if (recover) begin
                        mode <= MD_RUN;
                        occ  <= '0;
                    end else if (run_done)
                        occ <= occ + 1'b1;
                end
                default: mode <= MD_SYNC;
            endcase
        end
    end

    // error state from mode and counter levels
    always_comb begin
        if (mode == MD_SYNC)                  st = FC_SYNC;
        else if (mode == MD_BOFF || boff_hit) st = FC_BUSOFF;
        else if (passive)                     st = FC_PASSIVE;
        else if (warn)                        st = FC_WARN;
        else                                  st = FC_ACTIVE;
    end

    // output mapping
    always_comb begin
        st_o     = st;
        tec_o    = boff_hit ? 8'hFF : tec[7:0];
        rec_o    = rec;
        drv_en   = st == FC_ACTIVE || st == FC_WARN || st == FC_PASSIVE;
        flag_dom = st == FC_ACTIVE || st == FC_WARN;
    end
endmodule

// File: rtl/can_fc_checker.sv
// Assertion checker for can_fault_conf, attached by bind.
// Assumes: the top's port names as listed in the bind below.
module can_fc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       ev_rx_ok,
    input logic [7:0] tec_o,
    input logic [7:0] rec_o,
    input logic [2:0] st_o,
    input logic       drv_en,
    input logic       flag_dom
);
    a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_o == 3'd0 && tec_o == 8'd0 && rec_o == 8'd0));

    a_r4_busoff_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        st_o == 3'd4 |-> (!drv_en && tec_o == 8'hFF));

    a_r3_passive_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_o == 3'd3 |-> !flag_dom);

    a_r10_rec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rec_o[7] && !ev_rx_ok && st_o != 3'd4) |=> $stable(rec_o));

    a_r5_recover_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o != 3'd4 && $past(st_o) == 3'd4) |-> (tec_o == 8'd0 && rec_o == 8'd0));

    a_r6_tec_steps: assert property (@(posedge clk) disable iff (!rst_n)
        tec_o != $past(tec_o) |->
            ({1'b0, tec_o} == {1'b0, $past(tec_o)} + 9'd8 ||
             {1'b0, tec_o} + 9'd1 == {1'b0, $past(tec_o)} ||
             tec_o == 8'd0 || tec_o == 8'hFF));

    a_r1_sync_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        st_o == 3'd0 |-> !drv_en);
endmodule

bind can_fault_conf can_fc_checker i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ev_rx_ok(ev_rx_ok),
    .tec_o(tec_o), .rec_o(rec_o), .st_o(st_o), .drv_en(drv_en), .flag_dom(flag_dom)
);

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;
    logic clk = 1'b0;
    logic rst_n, enable, bit_tick, bit_rec, flag_window, flag_passive, tx_role;
    logic ev_rx_err, ev_tx_err, ex_arb_stuff, ex_ack_quiet, ev_flag_bit_err, ev_rx_ok, ev_tx_ok;
    logic [7:0] tec_o, rec_o;
    logic [2:0] st_o;
    logic drv_en, flag_dom;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int mtec, mrec;
    bit msync;

    always #4 clk = ~clk;

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick), .bit_rec(bit_rec),
        .flag_window(flag_window), .flag_passive(flag_passive), .tx_role(tx_role),
        .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err), .ex_arb_stuff(ex_arb_stuff),
        .ex_ack_quiet(ex_ack_quiet), .ev_flag_bit_err(ev_flag_bit_err),
        .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .tec_o(tec_o), .rec_o(rec_o),
        .st_o(st_o), .drv_en(drv_en), .flag_dom(flag_dom)
    );

    function automatic int exp_state();
        if (msync) return 0;
        if (mtec > 255) return 4;
        if (mtec > 127 || mrec > 127) return 3;
        if (mtec > 95 || mrec > 95) return 2;
        return 1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        int es = exp_state();
        chk(req, "state", st_o, es);
        chk(req, "tec", tec_o, (mtec > 255) ? 255 : mtec);
        chk(req, "rec", rec_o, mrec);
        chk(req, "drv_en", drv_en, (es >= 1 && es <= 3) ? 1 : 0);
        chk(req, "flag_dom", flag_dom, (es == 1 || es == 2) ? 1 : 0);
    endtask

    task automatic clr_in();
        bit_tick = 0; bit_rec = 1; ev_rx_err = 0; ev_tx_err = 0; ex_arb_stuff = 0;
        ex_ack_quiet = 0; ev_flag_bit_err = 0; ev_rx_ok = 0; ev_tx_ok = 0;
    endtask

    // reference update per event kind
    task automatic model_apply(int k, bit role);
        bit pas = (mtec > 127 || mrec > 127);
        if (msync || mtec > 255) return;
        case (k)
            1: if (mrec < 128) mrec += 1;
            2: mtec += 8;
            4: if (!pas) mtec += 8;
            5: if (role) mtec += 8; else if (mrec < 128) mrec += 8;
            6: if (mrec > 0) mrec -= 1;
            7: if (mtec > 0) mtec -= 1;
            default: ;
        endcase
    endtask

    // kinds: 1 rx err, 2 tx err, 3 tx err arb-stuff, 4 tx err ack-quiet,
    // 5 flag bit err, 6 rx ok, 7 tx ok
    task automatic ev(int k, bit role);
        tx_role = role;
        case (k)
            1: ev_rx_err = 1;
            2: ev_tx_err = 1;
            3: begin ev_tx_err = 1; ex_arb_stuff = 1; end
            4: begin ev_tx_err = 1; ex_ack_quiet = 1; end
            5: ev_flag_bit_err = 1;
            6: ev_rx_ok = 1;
            7: ev_tx_ok = 1;
            default: ;
        endcase
        @(negedge clk);
        clr_in();
        model_apply(k, role);
    endtask

    task automatic bits(int n, bit rec);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; bit_rec = rec;
            @(negedge clk);
            bit_tick = 0; bit_rec = 1;
        end
    endtask

    task automatic resync();
        enable = 0;
        @(negedge clk);
        enable = 1;
        mtec = 0; mrec = 0; msync = 1;
        check_all("R12");
        bits(11, 1);
        msync = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clr_in();
        rst_n = 0; enable = 1; flag_window = 0; flag_passive = 0; tx_role = 0;
        mtec = 0; mrec = 0; msync = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1");
        // R1: events ignored while synchronizing
        ev(2, 1); ev(1, 0);
        check_all("R1");
        // R1: dominant tick restarts the start-up run
        bits(10, 1); bits(1, 0); bits(10, 1);
        check_all("R1");
        bits(1, 1); msync = 0;
        check_all("R1");

        // random bursts: R2 R3 R6 R7 R9 R10 R11
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 80; i++) begin
                int r = $urandom % 16;
                int k = (r < 3) ? 1 : (r < 4) ? 2 : (r < 5) ? 3 : (r < 6) ? 4 :
                        (r < 7) ? 5 : (r < 11) ? 6 : 7;
                ev(k, 1'($urandom % 2));
                check_all("R6 R9 random");
            end
            resync();
        end

        // R2 warning boundary
        for (int i = 0; i < 11; i++) ev(2, 1);
        chk("R2", "state at 88", st_o, 1);
        ev(2, 1);
        check_all("R2");
        chk("R2", "state at 96", st_o, 2);
        ev(7, 1);
        chk("R2", "state at 95", st_o, 1);
        // R3 passive boundary and R11 exemptions
        for (int i = 0; i < 4; i++) ev(2, 1);
        chk("R3", "state at 127", st_o, 2);
        ev(2, 1);
        check_all("R3");
        chk("R3", "flag_dom passive", flag_dom, 0);
        ev(4, 1);
        chk("R11", "ack-quiet in passive", tec_o, 135);
        ev(3, 1);
        chk("R11", "arb-stuff", tec_o, 135);
        for (int i = 0; i < 8; i++) ev(7, 1);
        check_all("R3");
        chk("R3", "state back at 127", st_o, 2);

        // R10 receive freeze, R7 role routing
        resync();
        ev(5, 1);
        chk("R7", "flag bit err tx", tec_o, 8);
        for (int i = 0; i < 128; i++) ev(1, 0);
        check_all("R10");
        ev(1, 0); ev(5, 0);
        chk("R10", "rec frozen", rec_o, 128);
        ev(6, 0);
        chk("R9", "rec dec", rec_o, 127);

        // R11 ack-quiet counts outside passive, R9 floor
        resync();
        ev(4, 1);
        chk("R11", "ack-quiet active", tec_o, 8);
        ev(6, 0);
        chk("R9", "rec floor", rec_o, 0);
        ev(3, 1);
        chk("R11", "arb-stuff active", tec_o, 8);

        // R8 post-flag dominant penalties
        flag_window = 1; flag_passive = 0; tx_role = 0;
        bits(13, 0);
        chk("R8", "13 dominant", rec_o, 0);
        bits(1, 0);
        chk("R8", "14th dominant", rec_o, 8);
        bits(7, 0);
        chk("R8", "7 further", rec_o, 8);
        bits(1, 0);
        chk("R8", "8th further", rec_o, 16);
        bits(1, 1);
        flag_passive = 1; tx_role = 1;
        bits(7, 0);
        chk("R8", "passive 7", tec_o, 8);
        bits(1, 0);
        chk("R8", "passive 8th", tec_o, 16);
        flag_window = 0; flag_passive = 0; tx_role = 0;
        mtec = 16; mrec = 16;
        check_all("R8");

        // R4 bus off and R5 recovery
        resync();
        for (int i = 0; i < 31; i++) ev(2, 1);
        chk("R4", "state at 248", st_o, 3);
        ev(2, 1);
        check_all("R4");
        ev(7, 1);
        check_all("R4");
        for (int i = 0; i < 127; i++) bits(11, 1);
        bits(10, 1);
        check_all("R5");
        bits(1, 0);
        bits(10, 1);
        chk("R5", "before last run ends", st_o, 4);
        bits(1, 1);
        mtec = 0; mrec = 0;
        check_all("R5");
        chk("R5", "active after recovery", st_o, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule